// File: doc/BRIEF.md
# Multiplexed Address/Data Read Controller

This block runs single asynchronous read cycles on an 8-bit external memory that shares one 16-bit bus for address and data. A host raises a request with a 16-bit address, a strobe length in core cycles, a hold-cycle enable and an address-latch polarity. The controller then drives the external pins through a fixed sequence. First an address-latch pulse with the whole address on both byte lanes. Then a turnaround cycle. Then a read strobe during which the low lane is released to the memory while the high lane keeps carrying the upper address. Last come the trailing cycles that close the access.

Every phase lasts a whole number of core-clock cycles. The returned byte is captured on the clock edge where the read strobe goes inactive. A one-cycle done pulse marks the end of the access. The bus is split into a driven value, an input value and one output enable per byte lane. A pad ring or a tri-state wrapper combines them into the physical bidirectional pins.

Top module: `muxad_rd_ctrl`

## Requirements
- R1: After reset and whenever no access is running, the latch output is at its inactive level, the active-low read strobe is high, both lane enables `ad_oe_o[1:0]` are 0 and `done_o` is 0. After reset the inactive latch level is 0.
- R2: If `ale_low_i` is 1 when a request is accepted, the latch output is active low for that access, and its idle level stays 1 afterwards. If it is 0, the latch output is active high and idles at 0. Polarity changes no other output.
- R3: A request is accepted at a clock edge where `req_i` is 1 and the block is idle. The latch output is active in cycles 1 and 2 after that edge. In those cycles `ad_o` carries the full address and both lane enables are 1.
- R4: In cycle 3 the latch output is inactive and the read strobe is still high. Both lanes still drive the address. The write strobe `wr_n_o` is 1 in every cycle.
- R5: The read strobe is low from cycle 4 through cycle 3+N, where N is the data-cycle count sampled at acceptance.
- R6: While the read strobe is low, `ad_oe_o[0]` is 0 and `ad_oe_o[1]` is 1, with `ad_o[15:8]` equal to address bits 15:8.
- R7: `rdata_o` takes the value of `ad_i` during the last low cycle of the read strobe. It is updated at the edge where the strobe goes high and holds that value until the next capture.
- R8: In cycle 4+N the read strobe is high, the low lane is released and the high lane still drives address bits 15:8.
- R9: With the hold enable set, cycle 5+N is an extra cycle with the strobe high and no lane driven. Without it, no such cycle exists.
- R10: `done_o` is 1 for exactly one cycle, in cycle 5+N without hold or 6+N with hold. The block is idle in the following cycle.
- R11: A request raised while an access is running is ignored. The running access keeps the address, count, hold enable and polarity sampled at its acceptance.
- R12: A data-cycle count of 0 behaves exactly like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | 16 | Target address |
| dcyc_i | input | 4 | Read-strobe length in core cycles (0 means 1) |
| hold_en_i | input | 1 | Adds one trailing hold cycle |
| ale_low_i | input | 1 | 1 makes the latch output active low |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-cycle completion pulse |
| ale_o | output | 1 | Address-latch output |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low, always inactive |
| ad_o | output | 16 | Value driven onto the shared bus |
| ad_oe_o | output | 2 | Per-lane output enable, bit 0 for AD[7:0], bit 1 for AD[15:8] |
| ad_i | input | 8 | Value on AD[7:0] as seen from the bus |

## Verification
Every pin result is fixed by its cycle number after the accepting edge. The latch is due in cycles 1 and 2 and the turnaround in cycle 3. The strobe runs from cycle 4 to 3+N, followed by the lane-1-only cycle, the optional hold cycle and the done pulse, with the captured byte checked in the done cycle. The bench counts edges from acceptance and samples at each following falling edge. It compares every output against a phase computed by a bench function from N and the hold flag. It also changes the byte on `ad_i` every cycle, so that only a capture in the last strobe cycle matches.

// File: rtl/muxad_pkg.sv
package muxad_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ALE   = 3'd1,
        PH_AHOLD = 3'd2,
        PH_STRB  = 3'd3,
        PH_DHOLD = 3'd4,
        PH_XHOLD = 3'd5,
        PH_DONE  = 3'd6
    } phase_e;

endpackage

// File: rtl/muxad_seq.sv
module muxad_seq
    import muxad_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DCW     = 4,
    parameter int ALE_CYC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DCW-1:0] dcyc_i,
    input  logic           hold_en_i,
    input  logic           ale_low_i,
    output phase_e         phase_o,
    output logic [AW-1:0]  addr_o,
    output logic           pol_o,
    output logic           cap_o
);

    localparam int CW = DCW + 1;

    typedef struct packed {
        phase_e         ph;
        logic [CW-1:0]  cnt;
        logic [DCW-1:0] dcyc;
        logic           hold;
        logic           pol;
        logic [AW-1:0]  addr;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.ph   = PH_ALE;
                    st_d.cnt  = CW'(ALE_CYC - 1);
                    st_d.dcyc = (dcyc_i == '0) ? DCW'(1) : dcyc_i;
                    st_d.hold = hold_en_i;
                    st_d.pol  = ale_low_i;
                    st_d.addr = addr_i;
                end
            end
            PH_ALE: begin
                if (st_q.cnt == '0) st_d.ph  = PH_AHOLD;
                else                st_d.cnt = st_q.cnt - CW'(1);
            end
            PH_AHOLD: begin
                st_d.ph  = PH_STRB;
                st_d.cnt = CW'(st_q.dcyc) - CW'(1);
            end
            PH_STRB: begin
                if (st_q.cnt == '0) st_d.ph  = PH_DHOLD;
                else                st_d.cnt = st_q.cnt - CW'(1);
            end
            PH_DHOLD: st_d.ph = st_q.hold ? PH_XHOLD : PH_DONE;
            PH_XHOLD: st_d.ph = PH_DONE;
            PH_DONE:  st_d.ph = PH_IDLE;
            default:  st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, dcyc: '0, hold: 1'b0, pol: 1'b0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign addr_o  = st_q.addr;
    assign pol_o   = st_q.pol;
    assign cap_o   = (st_q.ph == PH_STRB) && (st_q.cnt == '0);

    // R11: sampled settings frozen while an access runs
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && $past(st_q.ph) != PH_IDLE)
            |-> ($stable(st_q.addr) && $stable(st_q.pol) && $stable(st_q.hold)));

    // R3: latch phase lasts at least two cycles
    a_r3_ale_two: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ALE && $past(st_q.ph) != PH_ALE) |=> (st_q.ph == PH_ALE));

    // R12: the stored count is never zero once an access runs
    a_r12_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_AHOLD) |-> (st_q.dcyc != '0));

endmodule

// File: rtl/muxad_pads.sv
module muxad_pads
    import muxad_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             pol_i,
    input  logic             cap_i,
    input  logic [DW-1:0]    ad_i,
    output logic             ale_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic [AW-1:0]    ad_o,
    output logic [AW/DW-1:0] ad_oe_o,
    output logic [DW-1:0]    rdata_o,
    output logic             done_o
);

    localparam int LANES = AW / DW;

    logic          ale_act;
    logic          addr_phase;
    logic          upper_phase;
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        ale_act     = (phase_i == PH_ALE);
        addr_phase  = (phase_i == PH_ALE) || (phase_i == PH_AHOLD);
        upper_phase = addr_phase || (phase_i == PH_STRB) || (phase_i == PH_DHOLD);
        rdata_d     = cap_i ? ad_i : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_data_lane
                assign ad_oe_o[g] = addr_phase;
            end else begin : g_addr_lane
                assign ad_oe_o[g] = upper_phase;
            end
        end
    endgenerate

    assign ale_o   = ale_act ^ pol_i;
    assign rd_n_o  = (phase_i != PH_STRB);
    assign wr_n_o  = 1'b1;
    assign ad_o    = (phase_i == PH_IDLE) ? '0 : addr_i;
    assign rdata_o = rdata_q;
    assign done_o  = (phase_i == PH_DONE);

    // R1: idle means nothing driven and no strobe
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_IDLE) |-> (ad_oe_o == '0 && rd_n_o && !done_o));

    // R4: no read strobe in the cycle the latch ends
    a_r4_gap_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_act) |-> (rd_n_o && ad_oe_o[0]));

    // R6: low lane released and high lane driven while reading
    a_r6_lane_split: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!ad_oe_o[0] && ad_oe_o[LANES-1]));

    // R8: high lane held one cycle after the strobe ends
    a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> (ad_oe_o[LANES-1] && !ad_oe_o[0]));

    // R7: byte captured at the strobe's rising edge
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> (rdata_o == $past(ad_i)));

    // R10: completion pulse is a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/muxad_rd_ctrl.sv
module muxad_rd_ctrl
    import muxad_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int DCW     = 4,
    parameter int ALE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DCW-1:0]   dcyc_i,
    input  logic             hold_en_i,
    input  logic             ale_low_i,
    output logic [DW-1:0]    rdata_o,
    output logic             done_o,
    output logic             ale_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic [AW-1:0]    ad_o,
    output logic [AW/DW-1:0] ad_oe_o,
    input  logic [DW-1:0]    ad_i
);

    phase_e        phase_w;
    logic [AW-1:0] addr_w;
    logic          pol_w;
    logic          cap_w;

    muxad_seq #(
        .AW      (AW),
        .DCW     (DCW),
        .ALE_CYC (ALE_CYC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .addr_i    (addr_i),
        .dcyc_i    (dcyc_i),
        .hold_en_i (hold_en_i),
        .ale_low_i (ale_low_i),
        .phase_o   (phase_w),
        .addr_o    (addr_w),
        .pol_o     (pol_w),
        .cap_o     (cap_w)
    );

    muxad_pads #(
        .AW (AW),
        .DW (DW)
    ) pads_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_w),
        .addr_i  (addr_w),
        .pol_i   (pol_w),
        .cap_i   (cap_w),
        .ad_i    (ad_i),
        .ale_o   (ale_o),
        .rd_n_o  (rd_n_o),
        .wr_n_o  (wr_n_o),
        .ad_o    (ad_o),
        .ad_oe_o (ad_oe_o),
        .rdata_o (rdata_o),
        .done_o  (done_o)
    );

endmodule

// File: tb/muxad_rd_ctrl_tb.sv
`timescale 1ns/1ps
module muxad_rd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  dcyc = '0;
    logic        hold = 1'b0;
    logic        pol = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  rdata;
    logic        done;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [15:0] ad_out;
    logic [1:0]  ad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    muxad_rd_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .addr_i    (addr),
        .dcyc_i    (dcyc),
        .hold_en_i (hold),
        .ale_low_i (pol),
        .rdata_o   (rdata),
        .done_o    (done),
        .ale_o     (ale),
        .rd_n_o    (rd_n),
        .wr_n_o    (wr_n),
        .ad_o      (ad_out),
        .ad_oe_o   (ad_oe),
        .ad_i      (ad_in)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // phase codes of the bench model: 0 idle, 1 latch, 2 turnaround,
    // 3 strobe, 4 upper hold, 5 extra hold, 6 done
    function automatic int exp_phase(input int k, input int ne, input bit h);
        if (k <= 2)          return 1;
        if (k == 3)          return 2;
        if (k <= 3 + ne)     return 3;
        if (k == 4 + ne)     return 4;
        if (h && k == 5 + ne) return 5;
        if (k == 5 + ne + (h ? 1 : 0)) return 6;
        return 0;
    endfunction

    function automatic logic [7:0] bus_byte(input logic [15:0] a, input int k);
        return a[7:0] ^ a[15:8] ^ 8'(k * 37 + 11);
    endfunction

    task automatic run_txn(input logic [15:0] a, input int n, input bit h,
                           input bit p, input bit inj);
        int ne;
        int last;
        logic [7:0] expd;
        string sfx;
        ne   = (n == 0) ? 1 : n;
        last = 6 + ne + (h ? 1 : 0);
        expd = '0;
        sfx  = inj ? "/R11" : ((n == 0) ? "/R12" : "");
        @(negedge clk);
        req = 1'b1; addr = a; dcyc = 4'(n); hold = h; pol = p;
        @(posedge clk);
        for (int k = 1; k <= last; k++) begin
            int ph;
            string tg;
            @(negedge clk);
            ph = exp_phase(k, ne, h);
            case (ph)
                1: tg = "R3";
                2: tg = "R4";
                3: tg = "R5/R6";
                4: tg = "R8";
                5: tg = "R9";
                6: tg = "R10";
                default: tg = "R1";
            endcase
            tg = {tg, sfx};
            chk({"R2 ale ", tg}, 16'(ale), 16'((ph == 1) ? !p : p));
            chk({"rd ", tg}, 16'(rd_n), 16'(ph != 3));
            chk({"R4 wr ", tg}, 16'(wr_n), 16'h1);
            chk({"oe ", tg}, 16'(ad_oe), 16'((ph == 1 || ph == 2) ? 2'b11 :
                                           (ph == 3 || ph == 4) ? 2'b10 : 2'b00));
            chk({"done ", tg}, 16'(done), 16'(ph == 6));
            if (ph == 1 || ph == 2) chk({"addr ", tg}, ad_out, a);
            if (ph == 3 || ph == 4) chk({"upper ", tg}, 16'(ad_out[15:8]), 16'(a[15:8]));
            if (ph == 6) chk({"R7 rdata", sfx}, 16'(rdata), 16'(expd));
            if (inj && k == 2) begin
                req = 1'b1; addr = ~a; dcyc = 4'd1; hold = ~h; pol = ~p;
            end else begin
                req = 1'b0;
            end
            ad_in = bus_byte(a, k);
            if (k == 3 + ne) expd = ad_in;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ale", 16'(ale), 16'h0);
        chk("R1 reset rd", 16'(rd_n), 16'h1);
        chk("R1 reset oe", 16'(ad_oe), 16'h0);
        chk("R1 reset done", 16'(done), 16'h0);
        chk("R4 reset wr", 16'(wr_n), 16'h1);

        run_txn(16'hA55A, 0, 1'b0, 1'b0, 1'b0);   // R12 zero count
        run_txn(16'h1234, 1, 1'b0, 1'b0, 1'b0);
        run_txn(16'hBEEF, 0, 1'b1, 1'b1, 1'b0);   // R12 with hold, low polarity
        run_txn(16'h00FF, 15, 1'b1, 1'b0, 1'b0);  // longest strobe, R9
        run_txn(16'hFF00, 3, 1'b0, 1'b1, 1'b1);   // R11 request while busy
        run_txn(16'h7E81, 2, 1'b1, 1'b0, 1'b1);

        for (int i = 0; i < 40; i++) begin
            run_txn(16'($urandom()), int'($urandom_range(0, 15)),
                    bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                    bit'($urandom_range(0, 1)));
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule